// File: doc/BRIEF.md
# I2C Wiper Register Slave

This block is a bus target that keeps one 7-bit wiper code for a digitally controlled resistor and presents it in parallel to a downstream tap decoder. It runs on a fast system clock. SCL and SDA pass through synchronizers, and the block finds bus conditions and SCL edges from the synchronized copies. It pulls SDA low through an open-drain output enable. The bus itself is outside the block.

The block answers to one fixed 7-bit address. The eighth bit of the address byte selects the direction.

- In a write, every following byte goes straight into the wiper register. The top bit of each byte is ignored. Any number of bytes may follow one address.
- In a read, the register comes back as a byte with a leading zero. It repeats for as long as the controller acknowledges.

After reset the code sits at midscale.

Top module: `i2c_wiper_slave`

## Requirements
- R1: While reset is asserted and right after it is released, `wiper_o` equals the preset 0x40 and `sda_oe_o` is 0 (SDA released).
- R2: A START is SDA falling while SCL is high. The first byte after it is the address in bits 7..1, sent MSB first, plus the direction in bit 0 (0 = write, 1 = read). When bits 7..1 equal 0101110, the slave pulls SDA low for the whole ninth SCL pulse.
- R3: When the address does not match, the slave does not acknowledge. It keeps SDA released for all following bits and leaves `wiper_o` unchanged until the next START.
- R4: In a write, each data byte is sent MSB first. Bit 7 is ignored and bits 6..0 become the new wiper code. The slave acknowledges each data byte on its ninth clock.
- R5: Every further data byte in the same write transaction updates the wiper, with no new address byte.
- R6: In a read, the slave drives the byte {0, wiper[6:0]} MSB first. Each bit changes while SCL is low.
- R7: If the controller acknowledges the ninth bit of a read byte (SDA low), the slave sends the register byte again. On a not-acknowledge (SDA high), it releases SDA until the next START or STOP.
- R8: A START or a STOP in the middle of a byte throws away the partial byte and leaves `wiper_o` unchanged. A repeated START begins a new address byte. A STOP returns the slave to idle with SDA released.
- R9: `sda_oe_o` changes only while the synchronized SCL is low.
- R10: `wiper_o` changes only as a result of a complete write data byte. The change lands on the SCL falling edge that ends the eighth data bit, before the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus (wired-AND value) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wiper_o | output | 7 | Current wiper code for the tap decoder |

## Verification
The bench builds the block with its default parameters: address 0101110, a 7-bit wiper, a preset of 0x40 and two synchronizer stages. SCL runs at one fortieth of the system clock. This ratio leaves several cycles of margin around the synchronizer delay, so the bench can check acknowledge and read-data timing at bit granularity. With a 7-bit wiper, writes with bit 7 set show that the top bit is discarded. The bench also cuts bytes short after four or five bits, which exercises the discard paths for repeated START and for STOP.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[0] <= '1;
          else        pipe_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= '1;
          else        pipe_q[s] <= pipe_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/wiper_slave_fsm.sv
module wiper_slave_fsm
  import wiper_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0101110,
  parameter int         WIPER_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [WIPER_W-1:0] wiper_i,
  output logic               load_en,
  output logic [WIPER_W-1:0] load_val,
  output logic               sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int PAD_W = BYTE_W - WIPER_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  slv_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic [BYTE_W-1:0]  tx_q, tx_d;
  logic               oe_q, oe_d;
  logic               rw_q, rw_d;
  logic               nack_q, nack_d;
  logic [BYTE_W-1:0]  rd_byte;

  assign rd_byte = {{PAD_W{1'b0}}, wiper_i};

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    tx_d     = tx_q;
    oe_d     = oe_q;
    rw_d     = rw_q;
    nack_d   = nack_q;
    load_en  = 1'b0;
    load_val = sh_q[WIPER_W-1:0];
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            if (state_q == ST_WDATA) begin
              load_en = 1'b1;
              oe_d    = 1'b1;
              state_d = ST_WACK;
            end else if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
              oe_d    = 1'b1;
              rw_d    = sh_q[0];
              state_d = ST_AACK;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              tx_d    = rd_byte;
              oe_d    = ~rd_byte[BYTE_W-1];
              state_d = ST_RDATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WDATA;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == FULL) begin
              oe_d    = 1'b0;
              state_d = ST_RACK;
            end else begin
              tx_d = {tx_q[BYTE_W-2:0], 1'b0};
              oe_d = ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_d = ST_SKIP;
            end else begin
              tx_d    = rd_byte;
              oe_d    = ~rd_byte[BYTE_W-1];
              cnt_d   = '0;
              state_d = ST_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
    end
  end

  assign sda_oe = oe_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s) else $error("oe moved with SCL high"); // R9
  AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !oe_q) else $error("driving while skipping"); // R3
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !oe_q)) else $error("stop not idle"); // R8
  AST_READ_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AACK && scl_fall && rw_q && !start_det && !stop_det) |=> oe_q)
    else $error("read first bit not zero"); // R6
endmodule

// File: rtl/wiper_reg.sv
module wiper_reg #(
  parameter int                 WIPER_W = 7,
  parameter logic [WIPER_W-1:0] PRESET  = 7'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [WIPER_W-1:0] load_val,
  output logic [WIPER_W-1:0] wiper_q
);
  logic [WIPER_W-1:0] wiper_d;

  always_comb begin
    wiper_d = wiper_q;
    if (load_en) wiper_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wiper_q <= PRESET;
    else        wiper_q <= wiper_d;
  end
endmodule

// File: rtl/i2c_wiper_slave.sv
module i2c_wiper_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'b0101110,
  parameter int         WIPER_W     = 7,
  parameter logic [WIPER_W-1:0] PRESET = 7'h40,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [WIPER_W-1:0] wiper_o
);
  logic [1:0] line_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic load_en;
  logic [WIPER_W-1:0] load_val;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(line_s)
  );

  i2c_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  wiper_slave_fsm #(.DEV_ADDR(DEV_ADDR), .WIPER_W(WIPER_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .wiper_i(wiper_o), .load_en(load_en), .load_val(load_val),
    .sda_oe(sda_oe_o)
  );

  wiper_reg #(.WIPER_W(WIPER_W), .PRESET(PRESET)) u_reg (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .wiper_q(wiper_o)
  );

  AST_WIPER_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_o) |-> $past(load_en)) else $error("wiper moved without byte"); // R10
endmodule

// File: tb/i2c_wiper_slave_tb_top.sv
module i2c_wiper_slave_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe_o;
  logic [6:0] wiper_o;

  int tests = 0;
  int fails = 0;
  int oe_viol = 0;
  bit done = 1'b0;
  logic [6:0] exp_q [$];

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe_o;

  i2c_wiper_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe_o), .wiper_o(wiper_o)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(Q);
    seen = sda_bus; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) clk_bit(v[i], s);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    send_bits(v, 8);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(nack, s);
  endtask

  // monitor: every wiper change must match the next queued expectation
  initial begin
    logic [6:0] prev;
    @(posedge rst_n);
    prev = wiper_o;
    forever begin
      @(negedge clk);
      if (wiper_o !== prev) begin
        if (exp_q.size() == 0) check("R10 unexpected wiper change", wiper_o, prev);
        else check("R4/R5 wiper update", wiper_o, exp_q.pop_front());
        prev = wiper_o;
      end
    end
  end

  // R9: output enable must not move while the bus SCL is high
  initial begin
    logic prev_oe;
    prev_oe = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && sda_oe_o !== prev_oe && scl_m) oe_viol++;
      prev_oe = sda_oe_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    wq(5);
    check("R1 preset in reset", wiper_o, 7'h40);
    rst_n = 1'b1;
    wq(5);
    check("R1 preset after reset", wiper_o, 7'h40);
    check("R1 sda released", sda_oe_o, 0);

    // R2/R4: single write, bit 7 ignored
    bus_start();
    send_byte(8'h5C, ack); check("R2 address ack write", ack, 1);
    exp_q.push_back(7'h25);
    send_byte(8'hA5, ack); check("R4 data ack", ack, 1);
    bus_stop();
    check("R4 wiper low seven bits", wiper_o, 7'h25);

    // R5: several bytes under one address
    bus_start();
    send_byte(8'h5C, ack);
    exp_q.push_back(7'h7F); send_byte(8'h7F, ack); check("R5 byte1 ack", ack, 1);
    check("R5 wiper after byte1", wiper_o, 7'h7F);
    exp_q.push_back(7'h00); send_byte(8'h00, ack); check("R5 byte2 ack", ack, 1);
    check("R5 wiper after byte2", wiper_o, 7'h00);
    exp_q.push_back(7'h01); send_byte(8'h81, ack); check("R5 byte3 ack", ack, 1);
    bus_stop();
    check("R5 wiper after byte3", wiper_o, 7'h01);

    // R6/R7: read, repeated read, then NACK
    bus_start();
    send_byte(8'h5D, ack); check("R2 address ack read", ack, 1);
    read_byte(1'b0, rd); check("R6 read leading zero", rd, 8'h01);
    read_byte(1'b1, rd); check("R7 repeated read", rd, 8'h01);
    wq(4);
    check("R7 released after nack", sda_oe_o, 0);
    bus_stop();

    // R3: wrong address, write then read
    bus_start();
    send_byte(8'h5E, ack); check("R3 no ack on mismatch", ack, 0);
    send_byte(8'h33, ack); check("R3 data ignored no ack", ack, 0);
    check("R3 wiper unchanged", wiper_o, 7'h01);
    bus_stop();
    bus_start();
    send_byte(8'h3B, ack); check("R3 no ack other read", ack, 0);
    read_byte(1'b1, rd); check("R3 bus stays released", rd, 8'hFF);
    bus_stop();

    // R8: partial byte then repeated START, then partial then STOP
    bus_start();
    send_byte(8'h5C, ack);
    send_bits(8'h6A, 4);
    bus_start();
    check("R8 partial discarded on start", wiper_o, 7'h01);
    send_byte(8'h5C, ack); check("R8 address after restart", ack, 1);
    exp_q.push_back(7'h12); send_byte(8'h12, ack);
    send_bits(8'h4F, 5);
    bus_stop();
    check("R8 partial discarded on stop", wiper_o, 7'h12);

    // R10: no update before the eighth bit completes
    bus_start();
    send_byte(8'h5C, ack);
    send_bits(8'hD5, 7);
    check("R10 unchanged after seven bits", wiper_o, 7'h12);
    exp_q.push_back(7'h55);
    begin
      logic s;
      clk_bit(1'b1, s);
      check("R10 updated at eighth-bit fall", wiper_o, 7'h55);
      clk_bit(1'b1, s);
      check("R4 ack on eighth-bit byte", s, 0);
    end
    // repeated START switches to read
    bus_start();
    send_byte(8'h5D, ack);
    read_byte(1'b1, rd); check("R6 read after restart", rd, 8'h55);
    bus_stop();

    wq(20);
    check("R10 all expected updates seen", exp_q.size(), 0);
    check("R9 oe moved with SCL high", oe_viol, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule